// File: doc/BRIEF.md
# Write-Once Thermal Shutdown Supervisor

This block sits beside a temperature sensing front end that delivers one signed 8-bit reading for each of four channels. Channel 0 is on-die and channels 1 to 3 are remote. The block compares every valid set of readings against two kinds of threshold. The first is a per-channel critical limit. The second is a per-remote-channel high limit. It drives an active-low system shutdown line and an alert line.

Each critical limit can be programmed exactly once after reset. The write that stores the limit also locks the slot and arms that channel's hardware shutdown path. The high limits can be rewritten at any time. Each of them feeds the shutdown line only when its link bit in the configuration register is set.

Status is kept in two sticky registers. The critical status register has one bit per channel. The interrupt status register holds a critical summary in bit 0 and a high-limit summary in bit 1. Reading a status register clears only those bits whose condition has gone away. Alert is the OR of the unmasked status bits, unless it is silenced globally.

The lock logic is a two-state machine per channel. SLOT_OPEN goes to SLOT_LOCKED on the first write that hits the slot, and SLOT_LOCKED only leaves on reset. The shutdown output comes from a second two-state machine. SD_ARMED goes to SD_TRIPPED when any trip source is active, and SD_TRIPPED goes back to SD_ARMED once none is.

Top module: `tsup_top`

## Requirements
- R1: After reset, each critical limit (addresses 00h-03h, channel n at 0n) reads 64h. Each high limit (11h-13h, channel n at 1nh) reads 55h. Configuration (20h), mask (23h) and both status registers (21h, 22h) read 00h. shdn_n is 1 and alert is 0.
- R2: A channel whose critical limit was never written causes no shutdown and sets no critical status bit, even if its reading is above the limit.
- R3: The first write to a critical limit stores the data and locks the slot. Every later write to that slot is ignored until reset. Read-back returns the stored value.
- R4: Once a slot is locked, a valid reading strictly above its limit sets critical status bit n (21h bit n) and interrupt bit 0 (22h bit 0) at that clock edge. shdn_n goes to 0 on the following edge.
- R5: All comparisons are signed two's complement. A reading equal to the critical limit does not count as above it.
- R6: shdn_n returns to 1 on the edge after a valid reading that leaves no trip source active.
- R7: Configuration bit n (n = 1..3) links the high limit of channel n to shutdown. A reading greater than or equal to that limit trips, and a reading below it releases. Any remote reading at or above its high limit sets interrupt bit 1, whether or not it is linked.
- R8: Status bits are sticky. A read of 21h or 22h returns the value before the read and clears only those bits whose condition is absent in the held comparison results.
- R9: Configuration bit 7 forces alert to 0. Configuration bits 0 and 4-6 read as 0.
- R10: With bit 7 clear, alert is 1 when any status bit is set and not masked. Mask register bit n masks critical status bit n, bit 6 masks interrupt bit 0 and bit 7 masks interrupt bit 1.
- R11: Writes to unmapped addresses and to the status registers change nothing. Reads of unmapped addresses return 00h.
- R12: When a status read and a valid reading that sets the same bit fall on one edge, the bit stays set.
- R13: Cycles without temp_valid leave the held comparison results, the status and shdn_n unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_valid | input | 1 | A new set of readings is present on temp_bus |
| temp_bus | input | 32 | Channel n reading in bits [8n+7:8n], signed |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; reg_rdata loads on this edge |
| reg_rdata | output | 8 | Registered read data |
| shdn_n | output | 1 | System shutdown, active low |
| alert | output | 1 | Alert, active high |

## Verification
A status read can fall on the same clock as a reading that sets the very bit being cleared. In that case the clear-if-absent rule and the set path compete for one flop. The bench provokes this in two steps. It first sets a critical status bit and then cools the channel without reading. It then issues the status read on the same edge as a new hot reading. The returned value must carry the bit, a second read must still show it, and shutdown must trip one edge later. The behavioural model in the bench settles each edge by applying the clear before the set.

// File: rtl/tsup_pkg.sv
package tsup_pkg;

    // Lock state of one critical limit slot
    typedef enum logic {
        SLOT_OPEN   = 1'b0,
        SLOT_LOCKED = 1'b1
    } slot_state_e;

    // Shutdown output state
    typedef enum logic {
        SD_ARMED   = 1'b0,
        SD_TRIPPED = 1'b1
    } sd_state_e;

    // Register map (channel offsets are added to the bases)
    localparam int CRIT_BASE  = 'h00;
    localparam int HIGH_BASE  = 'h10;
    localparam int CFG_ADDR   = 'h20;
    localparam int CSTAT_ADDR = 'h21;
    localparam int ISTAT_ADDR = 'h22;
    localparam int AMASK_ADDR = 'h23;

    // Reset values
    localparam int CRIT_RST = 'h64;
    localparam int HIGH_RST = 'h55;

    // Bit positions in configuration and mask registers
    localparam int CFG_SILENCE_BIT = 7;
    localparam int MSK_INT0_BIT    = 6;
    localparam int MSK_INT1_BIT    = 7;

endpackage

// File: rtl/tsup_limit_slot.sv
module tsup_limit_slot
    import tsup_pkg::*;
#(
    parameter int               DW        = 8,
    parameter int               AW        = 8,
    parameter logic [AW-1:0]    SLOT_ADDR = '0,
    parameter logic [DW-1:0]    RST_VAL   = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] limit,
    output logic          linked
);

    slot_state_e state_q, state_d;
    logic        hit;
    logic        take;

    assign hit = wr_en && (addr == SLOT_ADDR);

    // next state and capture enable
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SLOT_OPEN: begin
                if (hit) begin
                    state_d = SLOT_LOCKED;
                    take    = 1'b1;
                end
            end
            SLOT_LOCKED: begin
                state_d = SLOT_LOCKED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_OPEN;
        else        state_q <= state_d;
    end

    // limit storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    limit <= RST_VAL;
        else if (take) limit <= wdata;
    end

    assign linked = (state_q == SLOT_LOCKED);

endmodule

// File: rtl/tsup_compare.sv
module tsup_compare #(
    parameter int NCH = 4,
    parameter int DW  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  t_valid,
    input  logic [NCH*DW-1:0]     temp_bus,
    input  logic [NCH*DW-1:0]     crit_lim,
    input  logic [(NCH-1)*DW-1:0] high_lim,
    output logic [NCH-1:0]        crit_now,
    output logic [NCH-1:0]        high_now,
    output logic [NCH-1:0]        crit_hot,
    output logic [NCH-1:0]        high_hot
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic signed [DW-1:0] t_s;
        logic signed [DW-1:0] c_s;
        assign t_s         = temp_bus[g*DW +: DW];
        assign c_s         = crit_lim[g*DW +: DW];
        assign crit_now[g] = (t_s > c_s);
        if (g == 0) begin : g_internal
            assign high_now[g] = 1'b0;
        end else begin : g_remote
            logic signed [DW-1:0] h_s;
            assign h_s         = high_lim[(g-1)*DW +: DW];
            assign high_now[g] = (t_s >= h_s);
        end
    end

    // hold the last comparison results between readings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crit_hot <= '0;
            high_hot <= '0;
        end else if (t_valid) begin
            crit_hot <= crit_now;
            high_hot <= high_now;
        end
    end

endmodule

// File: rtl/tsup_status.sv
module tsup_status #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           t_valid,
    input  logic [NCH-1:0] crit_now,
    input  logic [NCH-1:0] high_now,
    input  logic [NCH-1:0] crit_hot,
    input  logic [NCH-1:0] high_hot,
    input  logic [NCH-1:0] linked,
    input  logic           rd_cstat,
    input  logic           rd_istat,
    input  logic           alert_off,
    input  logic [NCH-1:0] crit_msk,
    input  logic [1:0]     int_msk,
    output logic [NCH-1:0] crit_st,
    output logic [1:0]     int_st,
    output logic           alert
);

    logic [NCH-1:0] c_set, c_keep;
    logic [1:0]     i_set, i_keep;

    always_comb begin
        c_set     = t_valid ? (crit_now & linked) : '0;
        i_set[0]  = |c_set;
        i_set[1]  = t_valid && (|high_now);
        c_keep    = rd_cstat ? (crit_hot & linked) : '1;
        i_keep[0] = rd_istat ? (|(crit_hot & linked)) : 1'b1;
        i_keep[1] = rd_istat ? (|high_hot) : 1'b1;
    end

    // clear-if-absent first, then set; set wins on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crit_st <= '0;
            int_st  <= '0;
        end else begin
            crit_st <= (crit_st & c_keep) | c_set;
            int_st  <= (int_st & i_keep) | i_set;
        end
    end

    assign alert = !alert_off &&
                   ((|(crit_st & ~crit_msk)) || (|(int_st & ~int_msk)));

endmodule

// File: rtl/tsup_shutdown.sv
module tsup_shutdown
    import tsup_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic shdn_n
);

    sd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_ARMED:   if (trip)  state_d = SD_TRIPPED;
            SD_TRIPPED: if (!trip) state_d = SD_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SD_ARMED;
        else        state_q <= state_d;
    end

    assign shdn_n = (state_q != SD_TRIPPED);

endmodule

// File: rtl/tsup_top.sv
module tsup_top
    import tsup_pkg::*;
#(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              temp_valid,
    input  logic [NCH*DW-1:0] temp_bus,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [DW-1:0]     reg_rdata,
    output logic              shdn_n,
    output logic              alert
);

    localparam int            NREM  = NCH - 1;
    localparam logic [AW-1:0] A_CFG = AW'(CFG_ADDR);
    localparam logic [AW-1:0] A_CST = AW'(CSTAT_ADDR);
    localparam logic [AW-1:0] A_IST = AW'(ISTAT_ADDR);
    localparam logic [AW-1:0] A_MSK = AW'(AMASK_ADDR);

    logic [NCH*DW-1:0]  crit_lim;
    logic [NCH-1:0]     linked;
    logic [DW-1:0]      high_q [NREM];
    logic [NREM*DW-1:0] high_lim;
    logic               alert_off_q;
    logic [NREM-1:0]    hilink_q;
    logic [NCH-1:0]     crit_msk_q;
    logic [1:0]         int_msk_q;
    logic [NCH-1:0]     crit_now, high_now, crit_hot, high_hot;
    logic [NCH-1:0]     crit_st;
    logic [1:0]         int_st;
    logic               trip;
    logic [DW-1:0]      rd_mux;

    // write-once critical limit slots
    for (genvar g = 0; g < NCH; g++) begin : g_slot
        tsup_limit_slot #(
            .DW       (DW),
            .AW       (AW),
            .SLOT_ADDR(AW'(CRIT_BASE + g)),
            .RST_VAL  (DW'(CRIT_RST))
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (reg_wr),
            .addr  (reg_addr),
            .wdata (reg_wdata),
            .limit (crit_lim[g*DW +: DW]),
            .linked(linked[g])
        );
    end

    // freely writable high limits for remote channels 1..NCH-1
    for (genvar g = 0; g < NREM; g++) begin : g_high
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                high_q[g] <= DW'(HIGH_RST);
            else if (reg_wr && reg_addr == AW'(HIGH_BASE + g + 1))
                high_q[g] <= reg_wdata;
        end
        assign high_lim[g*DW +: DW] = high_q[g];
    end

    // configuration and mask registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alert_off_q <= 1'b0;
            hilink_q    <= '0;
            crit_msk_q  <= '0;
            int_msk_q   <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CFG) begin
                alert_off_q <= reg_wdata[CFG_SILENCE_BIT];
                hilink_q    <= reg_wdata[NCH-1:1];
            end
            if (reg_addr == A_MSK) begin
                crit_msk_q <= reg_wdata[NCH-1:0];
                int_msk_q  <= {reg_wdata[MSK_INT1_BIT], reg_wdata[MSK_INT0_BIT]};
            end
        end
    end

    tsup_compare #(
        .NCH(NCH),
        .DW (DW)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .t_valid (temp_valid),
        .temp_bus(temp_bus),
        .crit_lim(crit_lim),
        .high_lim(high_lim),
        .crit_now(crit_now),
        .high_now(high_now),
        .crit_hot(crit_hot),
        .high_hot(high_hot)
    );

    tsup_status #(
        .NCH(NCH)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .t_valid  (temp_valid),
        .crit_now (crit_now),
        .high_now (high_now),
        .crit_hot (crit_hot),
        .high_hot (high_hot),
        .linked   (linked),
        .rd_cstat (reg_rd && reg_addr == A_CST),
        .rd_istat (reg_rd && reg_addr == A_IST),
        .alert_off(alert_off_q),
        .crit_msk (crit_msk_q),
        .int_msk  (int_msk_q),
        .crit_st  (crit_st),
        .int_st   (int_st),
        .alert    (alert)
    );

    assign trip = (|(crit_hot & linked)) || (|(high_hot[NCH-1:1] & hilink_q));

    tsup_shutdown u_sd (
        .clk   (clk),
        .rst_n (rst_n),
        .trip  (trip),
        .shdn_n(shdn_n)
    );

    // read data selection
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_addr == AW'(CRIT_BASE + i)) rd_mux = crit_lim[i*DW +: DW];
        end
        for (int i = 0; i < NREM; i++) begin
            if (reg_addr == AW'(HIGH_BASE + i + 1)) rd_mux = high_q[i];
        end
        if (reg_addr == A_CFG) begin
            rd_mux[CFG_SILENCE_BIT] = alert_off_q;
            rd_mux[NCH-1:1]         = hilink_q;
        end
        if (reg_addr == A_CST) rd_mux[NCH-1:0] = crit_st;
        if (reg_addr == A_IST) rd_mux[1:0]     = int_st;
        if (reg_addr == A_MSK) begin
            rd_mux[NCH-1:0]      = crit_msk_q;
            rd_mux[MSK_INT0_BIT] = int_msk_q[0];
            rd_mux[MSK_INT1_BIT] = int_msk_q[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (reg_rd) reg_rdata <= rd_mux;
    end

endmodule

// File: rtl/tsup_checker.sv
module tsup_checker #(
    parameter int NCH = 4,
    parameter int DW  = 8,
    parameter int AW  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [AW-1:0]     reg_addr,
    input logic [NCH*DW-1:0] crit_lim,
    input logic [NCH-1:0]    linked,
    input logic [NCH-1:0]    crit_hot,
    input logic [NCH-1:0]    high_hot,
    input logic [NCH-2:0]    hilink,
    input logic [NCH-1:0]    crit_st,
    input logic              alert_off,
    input logic              alert,
    input logic              shdn_n
);

    logic locked_hit;
    logic any_trip;
    logic rd_cst;

    always_comb begin
        locked_hit = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (reg_wr && reg_addr == AW'(i) && linked[i]) locked_hit = 1'b1;
        end
    end

    assign any_trip = (|(crit_hot & linked)) || (|(high_hot[NCH-1:1] & hilink));
    assign rd_cst   = reg_rd && reg_addr == AW'(tsup_pkg::CSTAT_ADDR);

    // R3: a write to a locked slot leaves every limit unchanged
    a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        locked_hit |=> $stable(crit_lim));

    // R3: once linked, a slot stays linked
    a_r3_link_never_drops: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((linked & $past(linked)) == $past(linked)));

    // R4 / R7: an active trip source drives shutdown on the next edge
    a_r4_trip_asserts_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        any_trip |=> !shdn_n);

    // R6: with no trip source, shutdown is released on the next edge
    a_r6_release_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        !any_trip |=> shdn_n);

    // R8: critical status bits only fall on a read of their register
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cst |=> ((crit_st & $past(crit_st)) == $past(crit_st)));

    // R9: silence bit holds alert low
    a_r9_silence_alert: assert property (@(posedge clk) disable iff (!rst_n)
        alert_off |-> !alert);

endmodule

bind tsup_top tsup_checker #(
    .NCH(NCH),
    .DW (DW),
    .AW (AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .crit_lim (crit_lim),
    .linked   (linked),
    .crit_hot (crit_hot),
    .high_hot (high_hot),
    .hilink   (hilink_q),
    .crit_st  (crit_st),
    .alert_off(alert_off_q),
    .alert    (alert),
    .shdn_n   (shdn_n)
);

// File: tb/tb_tsup_top.sv
module tb_tsup_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        temp_valid = 1'b0;
    logic [31:0] temp_bus = '0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_rdata;
    logic        shdn_n;
    logic        alert;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    tsup_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .temp_valid(temp_valid),
        .temp_bus  (temp_bus),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .shdn_n    (shdn_n),
        .alert     (alert)
    );

    // ---------------- behavioural reference model ----------------
    int m_lim[4], m_lk[4], m_hi[4], m_hl[4], m_cm[4], m_cs[4], m_ch[4], m_hh[4];
    int m_im[2], m_is[2];
    int m_aoff, m_shdn, m_rdata;

    function automatic int s8(input int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    function automatic int rd_val(input int a);
        int v;
        v = 0;
        if (a >= 0 && a <= 3) v = m_lim[a];
        else if (a >= 'h11 && a <= 'h13) v = m_hi[a - 'h10];
        else if (a == 'h20) v = m_aoff * 128 + m_hl[1] * 2 + m_hl[2] * 4 + m_hl[3] * 8;
        else if (a == 'h21) v = m_cs[0] + m_cs[1] * 2 + m_cs[2] * 4 + m_cs[3] * 8;
        else if (a == 'h22) v = m_is[0] + m_is[1] * 2;
        else if (a == 'h23) v = m_cm[0] + m_cm[1] * 2 + m_cm[2] * 4 + m_cm[3] * 8
                               + m_im[0] * 64 + m_im[1] * 128;
        return v;
    endfunction

    function automatic int m_alert();
        int any;
        any = 0;
        for (int i = 0; i < 4; i++) if (m_cs[i] != 0 && m_cm[i] == 0) any = 1;
        for (int k = 0; k < 2; k++) if (m_is[k] != 0 && m_im[k] == 0) any = 1;
        return (m_aoff == 0) ? any : 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_lim[i] = 'h64; m_lk[i] = 0; m_hi[i] = 'h55; m_hl[i] = 0;
            m_cm[i] = 0; m_cs[i] = 0; m_ch[i] = 0; m_hh[i] = 0;
        end
        m_im[0] = 0; m_im[1] = 0; m_is[0] = 0; m_is[1] = 0;
        m_aoff = 0; m_shdn = 1; m_rdata = 0;
    endtask

    task automatic model_edge(input int a, input int d, input bit w, input bit r,
                              input bit tv, input logic [31:0] tb_temps);
        int nc[4];
        int nh[4];
        int trip, crit_any, high_any, t;
        trip = 0;
        for (int i = 0; i < 4; i++) begin
            if (m_ch[i] != 0 && m_lk[i] != 0) trip = 1;
            if (i > 0 && m_hh[i] != 0 && m_hl[i] != 0) trip = 1;
        end
        if (r) m_rdata = rd_val(a);
        for (int i = 0; i < 4; i++) begin
            t = s8(int'(tb_temps[i*8 +: 8]));
            nc[i] = (t > s8(m_lim[i])) ? 1 : 0;
            nh[i] = (i > 0 && t >= s8(m_hi[i])) ? 1 : 0;
        end
        // read clear where the held condition is gone
        if (r && a == 'h21)
            for (int i = 0; i < 4; i++) if (!(m_ch[i] != 0 && m_lk[i] != 0)) m_cs[i] = 0;
        if (r && a == 'h22) begin
            crit_any = 0; high_any = 0;
            for (int i = 0; i < 4; i++) begin
                if (m_ch[i] != 0 && m_lk[i] != 0) crit_any = 1;
                if (m_hh[i] != 0) high_any = 1;
            end
            if (crit_any == 0) m_is[0] = 0;
            if (high_any == 0) m_is[1] = 0;
        end
        // set from a new reading
        if (tv) begin
            for (int i = 0; i < 4; i++) begin
                if (nc[i] != 0 && m_lk[i] != 0) begin m_cs[i] = 1; m_is[0] = 1; end
                if (nh[i] != 0) m_is[1] = 1;
            end
        end
        // register writes
        if (w) begin
            if (a >= 0 && a <= 3 && m_lk[a] == 0) begin m_lim[a] = d; m_lk[a] = 1; end
            if (a >= 'h11 && a <= 'h13) m_hi[a - 'h10] = d;
            if (a == 'h20) begin
                m_aoff = (d >> 7) & 1;
                for (int i = 1; i < 4; i++) m_hl[i] = (d >> i) & 1;
            end
            if (a == 'h23) begin
                for (int i = 0; i < 4; i++) m_cm[i] = (d >> i) & 1;
                m_im[0] = (d >> 6) & 1; m_im[1] = (d >> 7) & 1;
            end
        end
        if (tv) for (int i = 0; i < 4; i++) begin m_ch[i] = nc[i]; m_hh[i] = nh[i]; end
        m_shdn = trip ? 0 : 1;
    endtask

    // ---------------- checking ----------------
    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one clock: drive at the falling edge, model at the rising edge, compare at the next falling edge
    task automatic step(input string tag, input int a, input int d, input bit w,
                        input bit r, input bit tv, input logic [31:0] tb_temps);
        reg_addr   = 8'(a);
        reg_wdata  = 8'(d);
        reg_wr     = w;
        reg_rd     = r;
        temp_valid = tv;
        temp_bus   = tb_temps;
        @(posedge clk);
        model_edge(a, d, w, r, tv, tb_temps);
        @(negedge clk);
        check(tag, "shdn_n", {7'd0, shdn_n}, 8'(m_shdn));
        check(tag, "alert", {7'd0, alert}, 8'(m_alert()));
        if (r) check(tag, $sformatf("rdata@%02h", a), reg_rdata, 8'(m_rdata));
        reg_wr = 1'b0; reg_rd = 1'b0; temp_valid = 1'b0;
    endtask

    logic [31:0] cur_t = '0;

    task automatic rd(input string tag, input int a);
        step(tag, a, 0, 1'b0, 1'b1, 1'b0, cur_t);
    endtask
    task automatic wr(input string tag, input int a, input int d);
        step(tag, a, d, 1'b1, 1'b0, 1'b0, cur_t);
    endtask
    task automatic tmp(input string tag, input int t0, input int t1, input int t2, input int t3);
        cur_t = {8'(t3), 8'(t2), 8'(t1), 8'(t0)};
        step(tag, 'hFF, 0, 1'b0, 1'b0, 1'b1, cur_t);
    endtask
    task automatic idle(input string tag);
        step(tag, 'hFF, 0, 1'b0, 1'b0, 1'b0, cur_t);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1", "shdn_n", {7'd0, shdn_n}, 8'h01);
        check("R1", "alert", {7'd0, alert}, 8'h00);
        for (int a = 0; a < 4; a++) rd("R1", a);
        for (int a = 'h11; a <= 'h13; a++) rd("R1", a);
        for (int a = 'h20; a <= 'h23; a++) rd("R1", a);

        // R2: hot readings on unlinked channels
        tmp("R2", 'h70, 'h70, 'h70, 'h70);
        idle("R2");
        rd("R2", 'h21);
        rd("R2", 'h22);
        tmp("R2", 'h10, 'h10, 'h10, 'h10);
        rd("R8", 'h22);
        rd("R8", 'h22);

        // R3: write once, later writes ignored
        wr("R3", 'h01, 'h50);
        wr("R3", 'h01, 'h20);
        rd("R3", 'h01);

        // R4: linked channel above limit trips
        tmp("R4", 'h10, 'h51, 'h10, 'h10);
        idle("R4");
        rd("R4", 'h21);
        rd("R4", 'h22);

        // R13: no valid reading leaves everything held
        step("R13", 'hFF, 0, 1'b0, 1'b0, 1'b0, 32'h10101010);
        idle("R13");

        // R8: read while still hot keeps the bit
        rd("R8", 'h21);

        // R5 / R6: equal reading releases, then read clears
        tmp("R5", 'h10, 'h50, 'h10, 'h10);
        idle("R6");
        rd("R8", 'h21);
        rd("R8", 'h21);
        rd("R8", 'h22);

        // R5: signed limit on channel 2
        wr("R5", 'h02, 'hF6);
        tmp("R5", 'h10, 'h10, 'hFB, 'h10);
        idle("R5");
        tmp("R5", 'h10, 'h10, 'hF6, 'h10);
        idle("R5");
        tmp("R5", 'h10, 'h10, 'h80, 'h10);
        idle("R5");
        rd("R5", 'h21);

        // R7: high limit link on channel 3
        wr("R7", 'h13, 'h30);
        tmp("R7", 'h10, 'h10, 'h80, 'h30);
        idle("R7");
        wr("R7", 'h20, 'h08);
        idle("R7");
        rd("R7", 'h20);
        tmp("R7", 'h10, 'h10, 'h80, 'h2F);
        idle("R7");
        rd("R7", 'h22);
        tmp("R7", 'h10, 'h10, 'h80, 'h30);
        idle("R7");

        // R9: silence bit, reserved bits read zero
        wr("R9", 'h20, 'hFF);
        idle("R9");
        rd("R9", 'h20);
        wr("R9", 'h20, 'h08);
        idle("R9");

        // R10: per-bit masking
        wr("R10", 'h23, 'hC0);
        idle("R10");
        wr("R10", 'h23, 'h40);
        idle("R10");
        rd("R10", 'h23);
        wr("R10", 'h23, 'h00);

        // R11: unmapped and status writes ignored
        wr("R11", 'h30, 'hAA);
        rd("R11", 'h30);
        wr("R11", 'h21, 'hFF);
        rd("R11", 'h21);
        wr("R11", 'h10, 'h00);
        rd("R11", 'h10);
        tmp("R11", 'h10, 'h10, 'h80, 'h10);
        idle("R11");

        // R12: status read and a setting reading on the same edge
        tmp("R12", 'h10, 'h60, 'h80, 'h10);
        tmp("R12", 'h10, 'h40, 'h80, 'h10);
        cur_t = 32'h10_80_60_10;
        step("R12", 'h21, 0, 1'b0, 1'b1, 1'b1, cur_t);
        rd("R12", 'h21);
        idle("R12");

        finish_run();
    end

endmodule